// File: doc/BRIEF.md
# Watchdog With Early Warning

This block is a watchdog timer for an embedded microcontroller. It counts system clock cycles from the last restart. If firmware does not restart it in time, it raises a reset request for a fixed number of cycles and then starts counting from zero again. Firmware restarts the count by writing the full byte 0xFF to the kick register. Any other byte value leaves the count running.

A short time before the counter would overflow, the block raises a warning flag. Firmware can use it to save state or log the event. The flag stays up until firmware writes a zero to it or the WAKE pin goes low. A restart does not clear it.

An overflow also sets a sticky cause bit. This bit lives in an always-on reset domain, so it survives the reset that the watchdog itself requests. Boot code can read it to tell a watchdog recovery from a power fault. Firmware clears it by writing zero. It is also held clear for as long as the external RESET pin is high.

Top module: `wdt_warn`

## Requirements
- R1: While `rst_ni` is low, `rst_req_o` and `warn_o` are 0. While `aon_rst_ni` is low, `ovf_o` is 0.
- R2: The count restarts from zero only on a write with `reg_sel_i` = 2'b00 and data 8'hFF. A write with any other data, or to any other select, leaves the overflow time unchanged.
- R3: Let W = TIMEOUT_CYC - LEAD_CYC. With no kick, `warn_o` rises on clock edge W after a restart, which is LEAD_CYC edges before overflow.
- R4: With no kick, `rst_req_o` rises on edge TIMEOUT_CYC after a restart and stays high for exactly HOLD_CYC cycles. Kicks are ignored while it is high. The count then restarts from zero, so the next overflow comes TIMEOUT_CYC edges after `rst_req_o` falls.
- R5: A write with `reg_sel_i` = 2'b01 and data bit 0 = 0 clears `warn_o` on the next edge. Writing bit 0 = 1 has no effect. A warning set in the same cycle wins over the clear.
- R6: A falling edge on the asynchronous `wake_i` clears `warn_o`. It passes through a two-stage synchronizer and an edge detector, so the flag clears on the third clock edge after `wake_i` falls.
- R7: A kick does not clear `warn_o`.
- R8: `ovf_o` is set on the overflow edge. It is held in the always-on domain, so asserting `rst_ni` does not clear it.
- R9: A write with `reg_sel_i` = 2'b10 and data bit 0 = 0 clears `ovf_o`. Writing bit 0 = 1 has no effect. An overflow in the same cycle wins over the clear.
- R10: While `reset_pin_i` is high, `ovf_o` is held at 0, even when an overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, main domain |
| aon_rst_ni | input | 1 | Active-low asynchronous reset, always-on domain (cause bit) |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_sel_i | input | 2 | 00 kick, 01 warning flag, 10 overflow cause, 11 none |
| reg_wdata_i | input | 8 | Write data |
| wake_i | input | 1 | WAKE pin level, asynchronous |
| reset_pin_i | input | 1 | RESET pin level; high holds the cause bit clear |
| rst_req_o | output | 1 | Reset request, high for HOLD_CYC cycles after overflow |
| warn_o | output | 1 | Early-warning flag |
| ovf_o | output | 1 | Sticky overflow cause bit |

## Verification
The assertions assume three things about the inputs:
- Register writes and `reset_pin_i` are synchronous to `clk_i`.
- `aon_rst_ni` is never asserted while `rst_ni` is released.
- `wake_i` is the only asynchronous input.

The stimulus respects these assumptions:
- Every write and every RESET pin change is driven on a falling clock edge.
- Both resets are released together at start-up, and after that only `rst_ni` is pulsed.
- WAKE is held high for many cycles before each falling edge, so the synchronizer never sees a glitch narrower than a clock.

Under these conditions, each property follows directly from the requirements. Examples: a kick while the warning is up leaves it up, and a reset request edge seen without RESET high always comes with the cause bit set.

// File: rtl/wdt_warn_pkg.sv
package wdt_warn_pkg;

  typedef enum logic [1:0] {
    SEL_KICK = 2'b00,
    SEL_WARN = 2'b01,
    SEL_STAT = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } wdt_state_e;

  localparam logic [7:0] KICK_KEY = 8'hFF;

endpackage

// File: rtl/wdt_wake_sync.sv
module wdt_wake_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= wake_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], wake_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_warn_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned LEAD_CYC    = 200,
  parameter int unsigned HOLD_CYC    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic rst_req_o,
  output logic warn_set_o,
  output logic ovf_evt_o
);

  localparam int unsigned CNT_W   = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int unsigned HOLD_W  = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam int unsigned WARN_AT = TIMEOUT_CYC - LEAD_CYC;

  wdt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              run, wrap, warn_hit;

  assign run      = (state_q == ST_RUN);
  assign wrap     = (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
  assign warn_hit = (cnt_q == CNT_W'(WARN_AT - 1));

  assign ovf_evt_o  = run & ~kick_i & wrap;
  assign warn_set_o = run & ~kick_i & warn_hit;
  assign rst_req_o  = ~run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (kick_i) begin
            cnt_q <= '0;
          end else if (wrap) begin
            cnt_q   <= '0;
            hold_q  <= HOLD_W'(HOLD_CYC - 1);
            state_q <= ST_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (hold_q == '0) state_q <= ST_RUN;
          else              hold_q  <= hold_q - 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hold_clr_i,
  output logic flag_o
);

  // hold_clr beats set, set beats clr
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (hold_clr_i) flag_o <= 1'b0;
    else if (set_i)      flag_o <= 1'b1;
    else if (clr_i)      flag_o <= 1'b0;
  end

endmodule

// File: rtl/wdt_warn.sv
module wdt_warn
  import wdt_warn_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned LEAD_CYC    = 200,
  parameter int unsigned HOLD_CYC    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       aon_rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       wake_i,
  input  logic       reset_pin_i,
  output logic       rst_req_o,
  output logic       warn_o,
  output logic       ovf_o
);

  reg_sel_e sel;
  logic     kick, warn_wr0, stat_wr0;
  logic     warn_set, ovf_evt, wake_fall;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign kick     = reg_we_i & (sel == SEL_KICK) & (reg_wdata_i == KICK_KEY);
  assign warn_wr0 = reg_we_i & (sel == SEL_WARN) & ~reg_wdata_i[0];
  assign stat_wr0 = reg_we_i & (sel == SEL_STAT) & ~reg_wdata_i[0];

  wdt_core #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .LEAD_CYC   (LEAD_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (kick),
    .rst_req_o (rst_req_o),
    .warn_set_o(warn_set),
    .ovf_evt_o (ovf_evt)
  );

  wdt_wake_sync #(.STAGES(SYNC_STAGES)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wake_i(wake_i),
    .fall_o(wake_fall)
  );

  wdt_flag u_warn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (warn_set),
    .clr_i     (warn_wr0 | wake_fall),
    .hold_clr_i(1'b0),
    .flag_o    (warn_o)
  );

  // always-on domain: survives rst_ni
  wdt_flag u_ovf (
    .clk_i     (clk_i),
    .rst_ni    (aon_rst_ni),
    .set_i     (ovf_evt),
    .clr_i     (stat_wr0),
    .hold_clr_i(reset_pin_i),
    .flag_o    (ovf_o)
  );

endmodule

// File: rtl/wdt_warn_chk.sv
module wdt_warn_chk #(
  parameter int unsigned HOLD_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       aon_rst_ni,
  input logic       reg_we_i,
  input logic [1:0] reg_sel_i,
  input logic [7:0] reg_wdata_i,
  input logic       reset_pin_i,
  input logic       rst_req_o,
  input logic       warn_o,
  input logic       ovf_o,
  input logic       warn_set,
  input logic       ovf_evt,
  input logic       wake_fall
);

  logic kick_wr;
  assign kick_wr = reg_we_i && reg_sel_i == 2'b00 && reg_wdata_i == 8'hFF;

  p_kick_keeps_warn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o && kick_wr && !wake_fall |=> warn_o);

  p_warn_wr_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i == 2'b01 && !reg_wdata_i[0] && !warn_set |=> !warn_o);

  p_wake_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_fall && !warn_set |=> !warn_o);

  p_ovf_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !aon_rst_ni)
    $rose(rst_req_o) && !$past(reset_pin_i) |-> ovf_o);

  p_stat_clear_r9: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    reg_we_i && reg_sel_i == 2'b10 && !reg_wdata_i[0] && !ovf_evt && !reset_pin_i |=> !ovf_o);

  p_pin_hold_r10: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    reset_pin_i |=> !ovf_o);

  generate
    if (HOLD_CYC > 1) begin : g_hold
      p_req_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |=> rst_req_o);
    end
  endgenerate

endmodule

bind wdt_warn wdt_warn_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .aon_rst_ni (aon_rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .reset_pin_i(reset_pin_i),
  .rst_req_o  (rst_req_o),
  .warn_o     (warn_o),
  .ovf_o      (ovf_o),
  .warn_set   (warn_set),
  .ovf_evt    (ovf_evt),
  .wake_fall  (wake_fall)
);

// File: tb/wdt_warn_tb_top.sv
`timescale 1ns/1ps
module wdt_warn_tb_top;

  localparam int unsigned T  = 40;
  localparam int unsigned L  = 8;
  localparam int unsigned H  = 4;
  localparam int unsigned W  = T - L;
  localparam int unsigned NV = 8;
  // {sel, data, restarts}
  localparam logic [10:0] VEC_TBL [NV] = '{
    {2'b00, 8'hFF, 1'b1}, {2'b00, 8'h00, 1'b0}, {2'b00, 8'hFE, 1'b0},
    {2'b00, 8'h7F, 1'b0}, {2'b00, 8'hF7, 1'b0}, {2'b01, 8'hFF, 1'b0},
    {2'b11, 8'hFF, 1'b0}, {2'b10, 8'hFF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, aon_rst_ni = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'b11;
  logic [7:0] reg_wdata = 8'h00;
  logic       wake = 1'b1, reset_pin = 1'b0;
  logic       rst_req, warn, ovf;
  int         n_chk = 0, n_bad = 0, cyc = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_warn #(.TIMEOUT_CYC(T), .LEAD_CYC(L), .HOLD_CYC(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .aon_rst_ni(aon_rst_ni),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .wake_i(wake), .reset_pin_i(reset_pin),
    .rst_req_o(rst_req), .warn_o(warn), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'b11; reg_wdata = 8'h00;
  endtask

  task automatic main_reset();
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
  endtask

  initial begin
    tick(3);
    chk("R1 req", rst_req, 1'b0);
    chk("R1 warn", warn, 1'b0);
    chk("R1 ovf", ovf, 1'b0);
    rst_ni = 1'b1; aon_rst_ni = 1'b1;

    // R2 table: kick key and non-kick writes
    for (int i = 0; i < NV; i++) begin
      main_reset();
      tick(10);
      wr(VEC_TBL[i][10:9], VEC_TBL[i][8:1]);
      tick(T - 11);
      chk($sformatf("R2 vec%0d at T", i), rst_req, ~VEC_TBL[i][0]);
      if (VEC_TBL[i][0]) begin
        tick(11);
        chk($sformatf("R2 vec%0d late", i), rst_req, 1'b1);
      end
    end

    // R3 / R4 / R8
    main_reset();
    wr(2'b10, 8'h00);
    main_reset();
    tick(W - 1);
    chk("R3 before", warn, 1'b0);
    tick(1);
    chk("R3 set", warn, 1'b1);
    tick(T - W - 1);
    chk("R4 before", rst_req, 1'b0);
    chk("R8 before", ovf, 1'b0);
    tick(1);
    chk("R4 rise", rst_req, 1'b1);
    chk("R8 set", ovf, 1'b1);
    wr(2'b00, 8'hFF);
    tick(H - 2);
    chk("R4 held", rst_req, 1'b1);
    tick(1);
    chk("R4 fall", rst_req, 1'b0);
    tick(T - 1);
    chk("R4 recount", rst_req, 1'b0);
    tick(1);
    chk("R4 second", rst_req, 1'b1);

    // R8 retention across main reset
    rst_ni = 1'b0;
    tick(2);
    chk("R8 in reset", ovf, 1'b1);
    chk("R1 warn in reset", warn, 1'b0);
    rst_ni = 1'b1;
    tick(1);
    chk("R8 after reset", ovf, 1'b1);

    // R9
    wr(2'b10, 8'h01);
    chk("R9 write1", ovf, 1'b1);
    wr(2'b10, 8'h00);
    chk("R9 write0", ovf, 1'b0);

    // R10
    main_reset();
    tick(T);
    chk("R10 pre", ovf, 1'b1);
    reset_pin = 1'b1;
    tick(1);
    chk("R10 clear", ovf, 1'b0);
    main_reset();
    tick(T);
    chk("R10 req", rst_req, 1'b1);
    chk("R10 held", ovf, 1'b0);
    reset_pin = 1'b0;

    // R5
    main_reset();
    tick(W);
    chk("R5 set", warn, 1'b1);
    wr(2'b01, 8'h01);
    chk("R5 write1", warn, 1'b1);
    wr(2'b01, 8'hFE);
    chk("R5 write0", warn, 1'b0);

    // R7 / R6
    main_reset();
    tick(W);
    wr(2'b00, 8'hFF);
    chk("R7 kick", warn, 1'b1);
    tick(T - W - 1);
    chk("R2 kicked", rst_req, 1'b0);
    chk("R7 later", warn, 1'b1);
    wake = 1'b0;
    tick(2);
    chk("R6 sync", warn, 1'b1);
    tick(1);
    chk("R6 clear", warn, 1'b0);
    wake = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule